// File: doc/BRIEF.md
# MDIO Management Controller

This block is a host-programmed master for the two-wire PHY management bus. A host reaches the management registers of an external PHY through two registers: a 32-bit command word and a 16-bit data word. Writing the command word with its busy bit set, while the engine is idle, launches one Clause-22 read or write frame on MDC/MDIO. The busy bit reads back as 1 until the frame has finished. For a write, the host loads the data word first. For a read, the host polls busy and then takes the returned value from the data word.

A build-time parameter `EXTENDED` selects one of two command-word layouts. The layouts differ in where the fields sit and in how the direction is encoded. A 4-bit clock-range code in the command word picks the MDC divider from a fixed table. In the legacy layout, a command write of all zeros produces a short burst of MDC edges without raising busy. This lets a PHY that waits for MDC activity leave its reset.

The engine is a state machine with the states ST_IDLE, ST_PREAMBLE, ST_HEADER, ST_TURN, ST_DATA and ST_WAKE. Its transitions are:
- ST_IDLE to ST_PREAMBLE when a valid command is accepted.
- ST_IDLE to ST_WAKE when the legacy all-zero word is accepted.
- ST_PREAMBLE to ST_HEADER after 32 bits.
- ST_HEADER to ST_TURN after 14 bits.
- ST_TURN to ST_DATA after 2 bits.
- ST_DATA to ST_IDLE after 16 bits.
- ST_WAKE to ST_IDLE after 32 bits.

Each bit lasts one MDC period. MDC goes low at the start of a bit, when MDIO is updated. MDC goes high at the middle of the bit, when read data is sampled.

Top module: `mdio_mgmt`

## Requirements
- R1: A command-word write (csr_addr=0) with bit 0 set, accepted while the engine is idle, starts a frame. cmd_rdata bit 0 reads 1 until the frame ends and then 0. cmd_rdata bits 31:1 read back the accepted word.
- R2: A frame is, MSB first: 32 ones, start bits 01, opcode (10 for read, 01 for write), 5-bit PHY address, 5-bit register address, turnaround, then 16 data bits. A write drives the turnaround as 10.
- R3: Legacy layout (EXTENDED=0): bit 1 is 1 for write and 0 for read. The PHY address is in bits 15:11, the register address in bits 10:6 and the clock-range code in bits 5:2.
- R4: Extended layout (EXTENDED=1): bits 3:2 hold the operation, 01 for write and 11 for read. The PHY address is in bits 25:21, the register address in bits 20:16 and the clock-range code in bits 11:8. Operation values 00 and 10 start no frame and leave busy at 0.
- R5: The data sent in a write frame is the value held in the data word (csr_addr=1) when the command is accepted.
- R6: In a read frame, mdio_oe is 0 for the turnaround and all 16 data bits. mdio_i is sampled at each MDC rise. After busy clears, data_rdata holds the 16 sampled bits, first bit as MSB.
- R7: MDIO changes while driven only where MDC falls. MDC is high whenever no frame or wake burst runs.
- R8: The MDC period in system clocks follows the clock-range code: 0→42, 1→62, 2→16, 3→26, 4→102, 5→124. Every other code gives 124. MDC is low for the first half of a period (rounded down).
- R9: Legacy only: a command write of all zeros gives 32 MDC periods with MDIO driven high, and cmd_rdata bit 0 stays 0 throughout.
- R10: A command write that arrives while a frame or wake burst is running is ignored. It changes neither the command word nor the MDC activity.
- R11: A data-word write that arrives while a frame or wake burst is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Register write strobe, one cycle |
| csr_addr | input | 1 | 0 selects the command word, 1 selects the data word |
| csr_wdata | input | 32 | Register write value (data word uses bits 15:0) |
| cmd_rdata | output | 32 | Command word readback; bit 0 is busy |
| data_rdata | output | 16 | Data word readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 drives the line) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check on every cycle four properties:
- MDC stays high while idle.
- A driven MDIO changes only together with an MDC fall.
- Busy never shows during a wake burst and drops only with MDC high.
- A command write under busy leaves the readback word unchanged.

Only the bench scenarios can show the rest:
- the bit content of each frame for both layouts;
- the divider chosen for every clock-range code;
- the release of MDIO in read frames and the captured read value;
- the 32-edge wake burst;
- the two rejected extended opcodes;
- the data word surviving writes made during a frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int CSR_W       = 32;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 5;
    localparam int CODE_W      = 4;
    localparam int MDC_DIV_MAX = 124;
    localparam int DIV_W       = $clog2(MDC_DIV_MAX + 1);
    localparam int BITCNT_W    = 5;
    localparam int SHIFT_W     = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;

    localparam logic [BITCNT_W-1:0] PRE_LAST = BITCNT_W'(31);
    localparam logic [BITCNT_W-1:0] HDR_LAST = BITCNT_W'(4 + 2 * ADDR_W - 1);
    localparam logic [BITCNT_W-1:0] TA_LAST  = BITCNT_W'(1);
    localparam logic [BITCNT_W-1:0] DAT_LAST = BITCNT_W'(DATA_W - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_WAKE
    } mdio_state_e;

    typedef struct packed {
        logic              start;
        logic              wake;
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [CODE_W-1:0] csel;
    } mdio_cmd_t;

    function automatic logic [DIV_W-1:0] div_for_code(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] d;
        unique case (code)
            4'd0:    d = DIV_W'(42);
            4'd1:    d = DIV_W'(62);
            4'd2:    d = DIV_W'(16);
            4'd3:    d = DIV_W'(26);
            4'd4:    d = DIV_W'(102);
            default: d = DIV_W'(MDC_DIV_MAX);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
    import mdio_mgmt_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  logic [CSR_W-1:0] word,
    output mdio_cmd_t        cmd
);

    logic unused_bits;
    assign unused_bits = ^word;

    generate
        if (EXTENDED) begin : g_ext
            logic [1:0] op;
            assign op        = word[3:2];
            assign cmd.wr    = (op == 2'b01);
            assign cmd.start = word[0] && op[0];
            assign cmd.wake  = 1'b0;
            assign cmd.phy   = word[25:21];
            assign cmd.regad = word[20:16];
            assign cmd.csel  = word[11:8];
        end else begin : g_legacy
            assign cmd.wr    = word[1];
            assign cmd.start = word[0];
            assign cmd.wake  = (word == '0);
            assign cmd.phy   = word[15:11];
            assign cmd.regad = word[10:6];
            assign cmd.csel  = word[5:2];
        end
    endgenerate

endmodule

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end,
    output logic             sample_pt,
    output logic             mdc_low
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half;

    assign half      = div >> 1;
    assign bit_end   = run && (cnt_q == div - DIV_W'(1));
    assign sample_pt = run && (cnt_q == half);
    assign mdc_low   = run && (cnt_q < half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || bit_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_mgmt_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic              csr_addr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  cmd_rdata,
    output logic [DATA_W-1:0] data_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    mdio_state_e         state_q, state_d;
    logic [BITCNT_W-1:0] bit_q;
    logic [SHIFT_W-1:0]  sh_q;
    logic [DATA_W-1:0]   rd_q;
    logic [DATA_W-1:0]   data_q;
    logic [CSR_W-1:0]    word_q;
    logic [DIV_W-1:0]    div_q;
    logic                wr_q;

    mdio_cmd_t cmd;
    logic      active, busy, accept_cmd, last_bit, step;
    logic      bit_end, sample_pt, mdc_low, shifting;

    mdio_cmd_decode #(.EXTENDED(EXTENDED)) u_dec (
        .word (csr_wdata),
        .cmd  (cmd)
    );

    mdio_mdc_timer u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .div       (div_q),
        .bit_end   (bit_end),
        .sample_pt (sample_pt),
        .mdc_low   (mdc_low)
    );

    assign active     = (state_q != ST_IDLE);
    assign accept_cmd = csr_wr && !csr_addr && !active;
    assign shifting   = (state_q == ST_HEADER) || (state_q == ST_TURN) || (state_q == ST_DATA);

    always_comb begin
        unique case (state_q)
            ST_PREAMBLE: last_bit = (bit_q == PRE_LAST);
            ST_HEADER:   last_bit = (bit_q == HDR_LAST);
            ST_TURN:     last_bit = (bit_q == TA_LAST);
            ST_DATA:     last_bit = (bit_q == DAT_LAST);
            ST_WAKE:     last_bit = (bit_q == PRE_LAST);
            default:     last_bit = 1'b0;
        endcase
    end

    assign step = bit_end && last_bit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_cmd && cmd.start)     state_d = ST_PREAMBLE;
                else if (accept_cmd && cmd.wake) state_d = ST_WAKE;
            end
            ST_PREAMBLE: if (step) state_d = ST_HEADER;
            ST_HEADER:   if (step) state_d = ST_TURN;
            ST_TURN:     if (step) state_d = ST_DATA;
            ST_DATA:     if (step) state_d = ST_IDLE;
            ST_WAKE:     if (step) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) bit_q <= '0;
            else if (bit_end)       bit_q <= bit_q + BITCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rd_q   <= '0;
            data_q <= '0;
            word_q <= '0;
            div_q  <= DIV_W'(MDC_DIV_MAX);
            wr_q   <= 1'b0;
        end else begin
            if (accept_cmd) begin
                word_q <= csr_wdata;
                div_q  <= div_for_code(cmd.csel);
                wr_q   <= cmd.wr;
                if (cmd.start) begin
                    sh_q <= {2'b01, (cmd.wr ? 2'b01 : 2'b10), cmd.phy, cmd.regad,
                             (cmd.wr ? 2'b10 : 2'b00), data_q};
                end
            end else if (bit_end && shifting) begin
                sh_q <= {sh_q[SHIFT_W-2:0], 1'b0};
            end
            if (sample_pt && state_q == ST_DATA) begin
                rd_q <= {rd_q[DATA_W-2:0], mdio_i};
            end
            if (csr_wr && csr_addr && !active) begin
                data_q <= csr_wdata[DATA_W-1:0];
            end else if (step && state_q == ST_DATA && !wr_q) begin
                data_q <= rd_q;
            end
        end
    end

    always_comb begin
        busy    = active && (state_q != ST_WAKE);
        mdc     = !mdc_low;
        mdio_o  = shifting ? sh_q[SHIFT_W-1] : 1'b1;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_PREAMBLE, ST_HEADER, ST_WAKE: mdio_oe = 1'b1;
            ST_TURN, ST_DATA:                mdio_oe = wr_q;
            default:                         mdio_oe = 1'b0;
        endcase
        cmd_rdata  = {word_q[CSR_W-1:1], busy};
        data_rdata = data_q;
    end

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
    import mdio_mgmt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             csr_wr,
    input logic             csr_addr,
    input logic [CSR_W-1:0] cmd_rdata,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input mdio_state_e      state
);

    AST_IDLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> mdc); // R7

    AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> (!mdc && $past(mdc))); // R7

    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[0] && csr_wr && !csr_addr) |=> (cmd_rdata[CSR_W-1:1] == $past(cmd_rdata[CSR_W-1:1]))); // R10

    AST_WAKE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> !cmd_rdata[0]); // R9

    AST_BUSY_DROPS_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rdata[0]) |-> mdc); // R1

endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .state     (state_q)
);

// File: tb/sim_mdio_mgmt.sv
module sim_mdio_mgmt;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        wr0 = 1'b0, wr1 = 1'b0, caddr = 1'b0, mdio_i = 1'b1;
    logic [31:0] wdata = '0;
    logic [31:0] cmd0, cmd1;
    logic [15:0] dat0, dat1;
    logic        mdc0, mdc1, o0, o1, oe0, oe1;

    mdio_mgmt #(.EXTENDED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_wr(wr0), .csr_addr(caddr), .csr_wdata(wdata),
        .cmd_rdata(cmd0), .data_rdata(dat0), .mdc(mdc0), .mdio_o(o0), .mdio_oe(oe0),
        .mdio_i(mdio_i));

    mdio_mgmt #(.EXTENDED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .csr_wr(wr1), .csr_addr(caddr), .csr_wdata(wdata),
        .cmd_rdata(cmd1), .data_rdata(dat1), .mdc(mdc1), .mdio_o(o1), .mdio_oe(oe1),
        .mdio_i(mdio_i));

    bit          sel = 1'b0;
    logic        mdc_m, o_m, oe_m;
    logic [31:0] cmd_m;
    logic [15:0] dat_m;
    assign mdc_m = sel ? mdc1 : mdc0;
    assign o_m   = sel ? o1 : o0;
    assign oe_m  = sel ? oe1 : oe0;
    assign cmd_m = sel ? cmd1 : cmd0;
    assign dat_m = sel ? dat1 : dat0;

    int checks = 0, errors = 0, cyc = 0;
    int neg0 = 0, neg1 = 0;
    bit low_seen0 = 1'b0;

    always @(negedge mdc0) neg0++;
    always @(negedge mdc1) neg1++;
    always @(posedge mdc0) if (!o0) low_seen0 = 1'b1;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        caddr = a;
        wdata = d;
        if (sel) wr1 = 1'b1; else wr0 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0;
        wr1 = 1'b0;
    endtask

    function automatic int div_of(input logic [3:0] code);
        case (code)
            4'd0: return 42;
            4'd1: return 62;
            4'd2: return 16;
            4'd3: return 26;
            4'd4: return 102;
            default: return 124;
        endcase
    endfunction

    function automatic logic [31:0] cmd_word(input bit ext, input bit wr, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [3:0] code);
        logic [31:0] w = '0;
        if (ext) begin
            w[25:21] = phy; w[20:16] = rg; w[11:8] = code;
            w[3:2] = wr ? 2'b01 : 2'b11;
        end else begin
            w[15:11] = phy; w[10:6] = rg; w[5:2] = code; w[1] = wr;
        end
        w[0] = 1'b1;
        return w;
    endfunction

    task automatic wait_idle(input string req);
        int n = 0;
        while (cmd_m[0] && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(!cmd_m[0], req, 64'(cmd_m[0]), 64'd0);
    endtask

    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [3:0] code, input logic [15:0] wd, input logic [15:0] rd);
        logic [31:0] w;
        logic [63:0] cap, oecap, exp, oexp;
        time t1, t2;
        w = cmd_word(sel, wr, phy, rg, code);
        if (wr) csr_write(1'b1, {16'h0, wd});
        csr_write(1'b0, w);
        chk(cmd_m == w, "R1 busy set and word readback", 64'(cmd_m), 64'(w));
        cap = '0; oecap = '0; t1 = 0; t2 = 0;
        for (int b = 0; b < 64; b++) begin
            if (b > 0) @(negedge mdc_m);
            if (b == 1) t1 = $time;
            if (b == 2) t2 = $time;
            #1;
            if (b >= 48) mdio_i = rd[63 - b];
            @(posedge mdc_m);
            #1;
            cap[63 - b]   = o_m;
            oecap[63 - b] = oe_m;
        end
        wait_idle("R1 busy clears");
        mdio_i = 1'b1;
        exp = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, (wr ? 2'b10 : 2'b00),
               (wr ? wd : 16'h0)};
        oexp = wr ? '1 : {46'h3FFF_FFFF_FFFF, 18'h0};
        if (!wr) cap[17:0] = '0;
        chk(cap == exp, sel ? "R2 R4 frame bits" : "R2 R3 frame bits", cap, exp);
        chk(oecap == oexp, wr ? "R2 write drive" : "R6 read release", oecap, oexp);
        chk(int'((t2 - t1) / CLK_PERIOD) == div_of(code), "R8 MDC period",
            64'((t2 - t1) / CLK_PERIOD), 64'(div_of(code)));
        if (wr) chk(dat_m == wd, "R5 data word kept", 64'(dat_m), 64'(wd));
        else    chk(dat_m == rd, "R6 read data", 64'(dat_m), 64'(rd));
    endtask

    initial begin
        int nsnap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd0 == 0 && cmd1 == 0, "R1 reset command word", 64'({cmd0, cmd1}), 64'd0);
        chk(dat0 == 0 && dat1 == 0, "R6 reset data word", 64'({dat0, dat1}), 64'd0);
        chk(mdc0 && mdc1 && !oe0 && !oe1, "R7 reset idle lines",
            64'({mdc0, mdc1, oe0, oe1}), 64'b1100);

        // Legacy: sweep all clock codes with write frames
        sel = 1'b0;
        for (int c = 0; c < 8; c++)
            run_frame(1'b1, 5'(c * 3 + 1), 5'(31 - c), 4'(c), 16'(16'hC3A5 ^ (c * 16'h1111)), 16'h0);
        run_frame(1'b0, 5'd0, 5'd2, 4'd2, 16'h0, 16'hB00F);
        run_frame(1'b0, 5'd31, 5'd31, 4'd3, 16'h0, 16'h0001);
        run_frame(1'b0, 5'd10, 5'd21, 4'd2, 16'h0, 16'h8000);

        // R9 wake burst, and R10 command ignored during it
        neg0 = 0; low_seen0 = 1'b0;
        csr_write(1'b0, 32'h0);
        chk(cmd0[0] == 1'b0, "R9 wake not busy", 64'(cmd0[0]), 64'd0);
        repeat (200) @(negedge clk);
        csr_write(1'b0, cmd_word(1'b0, 1'b1, 5'd3, 5'd4, 4'd2));
        chk(cmd0 == 32'h0, "R10 command ignored during wake", 64'(cmd0), 64'd0);
        repeat (32 * 42 + 100) @(negedge clk);
        chk(neg0 == 32, "R9 wake edge count", 64'(neg0), 64'd32);
        chk(!low_seen0, "R9 wake MDIO high", 64'(low_seen0), 64'd0);
        chk(cmd0[0] == 1'b0 && mdc0, "R10 no frame after wake", 64'({cmd0[0], mdc0}), 64'b01);

        // R10 / R11 writes during a frame
        csr_write(1'b1, 32'h0000_A5A5);
        csr_write(1'b0, cmd_word(1'b0, 1'b1, 5'd7, 5'd9, 4'd2));
        repeat (100) @(negedge clk);
        csr_write(1'b0, cmd_word(1'b0, 1'b0, 5'd1, 5'd1, 4'd5));
        csr_write(1'b1, 32'h0000_1234);
        chk(cmd0 == cmd_word(1'b0, 1'b1, 5'd7, 5'd9, 4'd2), "R10 command ignored while busy",
            64'(cmd0), 64'(cmd_word(1'b0, 1'b1, 5'd7, 5'd9, 4'd2)));
        wait_idle("R1 busy clears");
        chk(dat0 == 16'hA5A5, "R11 data write ignored while busy", 64'(dat0), 64'hA5A5);
        nsnap = neg0;
        repeat (150) @(negedge clk);
        chk(neg0 == nsnap && mdc0, "R10 no second frame", 64'(neg0), 64'(nsnap));

        // Extended layout
        sel = 1'b1;
        run_frame(1'b1, 5'd21, 5'd10, 4'd2, 16'h5A3C, 16'h0);
        run_frame(1'b0, 5'd17, 5'd3, 4'd3, 16'h0, 16'hFEED);
        run_frame(1'b0, 5'd1, 5'd30, 4'd9, 16'h0, 16'h6789);
        nsnap = neg1;
        for (int op = 0; op < 4; op += 2) begin
            logic [31:0] bad;
            bad = cmd_word(1'b1, 1'b1, 5'd2, 5'd2, 4'd2);
            bad[3:2] = 2'(op);
            csr_write(1'b0, bad);
            chk(cmd1[0] == 1'b0, "R4 invalid opcode not busy", 64'(cmd1[0]), 64'd0);
            repeat (60) @(negedge clk);
            chk(neg1 == nsnap, "R4 invalid opcode no MDC", 64'(neg1), 64'(nsnap));
        end
        run_frame(1'b1, 5'd0, 5'd0, 4'd2, 16'hFFFF, 16'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule